// File: doc/BRIEF.md
# Line-Oriented UART Debug Command Engine

This block connects a byte-wide UART receiver and transmitter to a 32-bit bus master port. It also has a byte-wide slave port on which a CPU sends characters to print. After reset the engine is in a pass-through mode: CPU bytes go straight to the transmitter, and received bytes are ignored except for the newline that switches the engine into a monitor mode.

In monitor mode the engine collects an ASCII line. It decodes the line as a command: read a word, write a word, return to pass-through, or restart the CPU at a new boot address. It answers each command with a fixed ASCII reply line. The CPU print port keeps accepting bytes in monitor mode but drops them, so a running program never stalls. Every bus access is a full aligned 32-bit word. The engine holds the request until the slave acknowledges, and only then starts the reply.

Top module: `dbg_line_engine`

## Requirements
- R1: After reset the engine is in pass-through mode: `tx_valid`/`tx_data` follow `usr_valid`/`usr_data` and `usr_ready` follows `tx_ready`; `bus_req` and `cpu_rst` are low.
- R2: In pass-through mode a received byte 0x0A switches to monitor mode. In monitor mode `usr_ready` is 1 and CPU bytes never appear on `tx_data`.
- R3: A monitor line of hex digits only issues one bus read (`bus_we`=0). The reply is the read word as exactly 8 lowercase hex digits, most significant first, then 0x0A.
- R4: A line of a hex address, one or more spaces, then hex data issues one bus write (`bus_we`=1) with that data. The reply is "wr done" then 0x0A.
- R5: The line "o" replies "user" then 0x0A and then returns to pass-through mode.
- R6: The line "r" followed by hex digits raises `cpu_rst` for exactly one cycle with `boot_addr` set to that value. The reply is "rst done" then 0x0A, and the engine returns to pass-through mode.
- R7: Any other non-empty line replies "invalid" then 0x0A and issues no bus access. This includes unknown characters, "r" with no digits, a trailing space and more than 8 digits in a field.
- R8: A line ends at 0x0A or 0x0D. An empty line, such as the second byte of 0x0D 0x0A, produces no reply and no bus access.
- R9: Hex digits are case-insensitive. Fewer than 8 digits are right-aligned, so leading zeros may be omitted.
- R10: `bus_req` stays high with a stable address until `bus_ack`. While it is high, `rx_ready` is low and no reply byte is offered.
- R11: Whenever `bus_req` is high, `bus_addr[1:0]` is 00 (the two low bits typed are cleared).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine takes the received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| usr_valid | input | 1 | CPU print byte available |
| usr_data | input | 8 | CPU print byte |
| usr_ready | output | 1 | CPU print byte taken |
| bus_req | output | 1 | Bus access request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| cpu_rst | output | 1 | One-cycle CPU restart pulse |
| boot_addr | output | 32 | Restart address, valid with `cpu_rst` |

## Verification
The hardest situation to reach is a line that arrives while the engine is still busy with the previous one. The clearest case is the 0x0A of a 0x0D 0x0A ending, which has to wait through a bus wait and a whole reply, and must then be dropped silently as an empty line. The bench gets there with a mixed-case read ended by 0x0D 0x0A against a slave that adds wait cycles. It checks that exactly one reply and one access appear. A second read runs with a transmitter that stalls every other cycle, which keeps the reply counter holding across back-pressure.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int WORD_W = 32;
  localparam int NIBS   = WORD_W / 4;
  localparam int IDX_W  = $clog2(NIBS + 1);

  typedef enum logic [2:0] {CMD_READ, CMD_WRITE, CMD_USER, CMD_RESET, CMD_BAD} cmd_e;
  typedef enum logic [2:0] {PS_START, PS_O, PS_R, PS_RADDR, PS_ADDR, PS_SP, PS_DATA, PS_BAD} pstate_e;
  typedef enum logic [1:0] {ST_USER, ST_COLLECT, ST_BUS, ST_REPLY} eng_e;

  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_O  = 8'h6F;
  localparam logic [7:0] CH_R  = 8'h72;

  localparam logic [71:0] TXT_WR  = "wr done\n";
  localparam logic [71:0] TXT_USR = "user\n";
  localparam logic [71:0] TXT_RST = "rst done\n";
  localparam logic [71:0] TXT_BAD = "invalid\n";

  function automatic logic is_hex(logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(logic [7:0] c);
    return (c <= 8'h39) ? c[3:0] : c[3:0] + 4'd9;
  endfunction

  function automatic logic [7:0] nib_char(logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
  endfunction

  function automatic logic [IDX_W-1:0] reply_last(cmd_e k);
    case (k)
      CMD_READ:  return IDX_W'(NIBS);
      CMD_WRITE: return IDX_W'(7);
      CMD_USER:  return IDX_W'(4);
      CMD_RESET: return IDX_W'(8);
      default:   return IDX_W'(7);
    endcase
  endfunction

  function automatic logic [7:0] pick(logic [71:0] s, int len, logic [IDX_W-1:0] i);
    return s[8*(len-1-int'(i)) +: 8];
  endfunction

  function automatic logic [7:0] reply_char(cmd_e k, logic [IDX_W-1:0] i, logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] t;
    t = w >> (4 * (NIBS - 1 - int'(i)));
    case (k)
      CMD_READ:  return (int'(i) < NIBS) ? nib_char(t[3:0]) : CH_LF;
      CMD_WRITE: return pick(TXT_WR, 8, i);
      CMD_USER:  return pick(TXT_USR, 5, i);
      CMD_RESET: return pick(TXT_RST, 9, i);
      default:   return pick(TXT_BAD, 8, i);
    endcase
  endfunction
endpackage

// File: rtl/dbg_line_parser.sv
module dbg_line_parser
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [7:0]        in_byte,
  output logic              line_end,
  output cmd_e              cmd,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q
);
  localparam int CNT_W = $clog2(NIBS + 1);

  pstate_e          ps;
  logic [CNT_W-1:0] ndig;
  logic             is_term, hexc, full;
  logic [3:0]       nib;

  assign is_term  = (in_byte == CH_LF) || (in_byte == CH_CR);
  assign hexc     = is_hex(in_byte);
  assign nib      = hex_val(in_byte);
  assign full     = (ndig == CNT_W'(NIBS));
  assign line_end = in_vld && is_term && (ps != PS_START);

  always_comb begin
    case (ps)
      PS_ADDR:  cmd = CMD_READ;
      PS_DATA:  cmd = CMD_WRITE;
      PS_O:     cmd = CMD_USER;
      PS_RADDR: cmd = CMD_RESET;
      default:  cmd = CMD_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= PS_START; ndig <= '0; addr_q <= '0; data_q <= '0;
    end else if (in_vld) begin
      if (is_term) begin
        ps <= PS_START; ndig <= '0; addr_q <= '0; data_q <= '0;
      end else begin
        case (ps)
          PS_START: begin
            if (in_byte == CH_O) ps <= PS_O;
            else if (in_byte == CH_R) ps <= PS_R;
            else if (hexc) begin
              ps <= PS_ADDR; addr_q <= WORD_W'(nib); ndig <= CNT_W'(1);
            end else ps <= PS_BAD;
          end
          PS_R: begin
            if (hexc) begin
              ps <= PS_RADDR; addr_q <= WORD_W'(nib); ndig <= CNT_W'(1);
            end else ps <= PS_BAD;
          end
          PS_ADDR, PS_RADDR: begin
            if (hexc && !full) begin
              addr_q <= {addr_q[WORD_W-5:0], nib}; ndig <= ndig + 1'b1;
            end else if (in_byte == CH_SP && ps == PS_ADDR) begin
              ps <= PS_SP; ndig <= '0;
            end else ps <= PS_BAD;
          end
          PS_SP: begin
            if (in_byte == CH_SP) ps <= PS_SP;
            else if (hexc) begin
              ps <= PS_DATA; data_q <= WORD_W'(nib); ndig <= CNT_W'(1);
            end else ps <= PS_BAD;
          end
          PS_DATA: begin
            if (hexc && !full) begin
              data_q <= {data_q[WORD_W-5:0], nib}; ndig <= ndig + 1'b1;
            end else ps <= PS_BAD;
          end
          default: ps <= PS_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_reply_tx.sv
module dbg_reply_tx
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_e              kind,
  input  logic [WORD_W-1:0] word,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              done
);
  logic              busy;
  logic [IDX_W-1:0]  idx;
  cmd_e              k_q;
  logic [WORD_W-1:0] w_q;
  logic              last;

  assign tx_valid = busy;
  assign tx_byte  = reply_char(k_q, idx, w_q);
  assign last     = (idx == reply_last(k_q));
  assign done     = busy && tx_ready && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; k_q <= CMD_BAD; w_q <= '0;
    end else if (start) begin
      busy <= 1'b1; idx <= '0; k_q <= kind; w_q <= word;
    end else if (busy && tx_ready) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/dbg_line_engine.sv
module dbg_line_engine
  import dbg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        usr_valid,
  input  logic [7:0]  usr_data,
  output logic        usr_ready,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        cpu_rst,
  output logic [31:0] boot_addr
);
  eng_e              st;
  cmd_e              cmd, cmd_q, rp_kind;
  logic              line_end, rp_start, rp_done, rp_valid, mode_user, is_bus_cmd;
  logic [7:0]        rp_byte;
  logic [WORD_W-1:0] p_addr, p_data;

  assign mode_user  = (st == ST_USER);
  assign rx_ready   = mode_user || (st == ST_COLLECT);
  assign bus_req    = (st == ST_BUS);
  assign bus_we     = (cmd_q == CMD_WRITE);
  assign is_bus_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE);

  dbg_line_parser u_parse (
    .clk(clk), .rst_n(rst_n),
    .in_vld(rx_valid && st == ST_COLLECT), .in_byte(rx_data),
    .line_end(line_end), .cmd(cmd), .addr_q(p_addr), .data_q(p_data)
  );

  assign rp_start = (st == ST_COLLECT && line_end && !is_bus_cmd) || (st == ST_BUS && bus_ack);
  assign rp_kind  = (st == ST_BUS) ? cmd_q : cmd;

  dbg_reply_tx u_reply (
    .clk(clk), .rst_n(rst_n), .start(rp_start), .kind(rp_kind), .word(bus_rdata),
    .tx_ready(tx_ready), .tx_valid(rp_valid), .tx_byte(rp_byte), .done(rp_done)
  );

  assign tx_valid  = mode_user ? usr_valid : rp_valid;
  assign tx_data   = mode_user ? usr_data  : rp_byte;
  assign usr_ready = mode_user ? tx_ready  : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_USER; cmd_q <= CMD_BAD; bus_addr <= '0; bus_wdata <= '0;
      cpu_rst <= 1'b0; boot_addr <= '0;
    end else begin
      cpu_rst <= 1'b0;
      case (st)
        ST_USER: if (rx_valid && rx_data == CH_LF) st <= ST_COLLECT;
        ST_COLLECT: if (line_end) begin
          cmd_q <= cmd;
          if (is_bus_cmd) begin
            st        <= ST_BUS;
            bus_addr  <= {p_addr[WORD_W-1:2], 2'b00};
            bus_wdata <= p_data;
          end else begin
            st <= ST_REPLY;
            if (cmd == CMD_RESET) begin
              cpu_rst   <= 1'b1;
              boot_addr <= p_addr;
            end
          end
        end
        ST_BUS: if (bus_ack) st <= ST_REPLY;
        default: if (rp_done)
          st <= (cmd_q == CMD_USER || cmd_q == CMD_RESET) ? ST_USER : ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/dbg_line_engine_chk.sv
module dbg_line_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        usr_ready,
  input logic        bus_req,
  input logic        bus_ack,
  input logic [31:0] bus_addr,
  input logic        cpu_rst,
  input logic        mode_user
);
  assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[1:0] == 2'b00);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr));
  assert_rx_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !rx_ready);
  assert_no_early_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !tx_valid);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |=> !cpu_rst);
  assert_rst_in_monitor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> !mode_user);
  assert_print_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_user |-> usr_ready);
  assert_reply_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !mode_user |=> tx_valid && $stable(tx_data));
endmodule

bind dbg_line_engine dbg_line_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .usr_ready(usr_ready),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
  .cpu_rst(cpu_rst), .mode_user(mode_user)
);

// File: tb/sim_dbg_line_engine.sv
module sim_dbg_line_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0; logic [7:0] rx_data = '0; logic rx_ready;
  logic tx_valid; logic [7:0] tx_data; logic tx_ready = 1'b1;
  logic usr_valid = 1'b0; logic [7:0] usr_data = '0; logic usr_ready;
  logic bus_req, bus_we, bus_ack = 1'b0; logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic cpu_rst; logic [31:0] boot_addr;

  localparam logic [31:0] RMASK = 32'hA5C3_0F1E;

  int errors = 0, checks = 0;
  int bus_cnt = 0, lat = 0, viol = 0, rst_cnt = 0;
  bit last_we = 0, stall = 0;
  logic [31:0] last_addr = '0, last_wdata = '0, last_boot = '0;
  string txlog = "";

  always #5 clk = ~clk;

  dbg_line_engine u0 (.*);

  always @(negedge clk) begin
    tx_ready = stall ? ~tx_ready : 1'b1;
    if (tx_valid && tx_ready) txlog = {txlog, $sformatf("%c", tx_data)};
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (lat == 2) begin
        bus_ack = 1'b1; bus_rdata = bus_addr ^ RMASK; bus_cnt++;
        last_we = bus_we; last_addr = bus_addr; last_wdata = bus_wdata; lat = 0;
      end else lat++;
    end
    if (rst_n && bus_req && (rx_ready || tx_valid)) viol++;
    if (cpu_rst) begin rst_cnt++; last_boot = boot_addr; end
  end

  task automatic check(bit ok, string req, string what, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%s exp=%s", req, what, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_line(string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic wait_reply();
    int n = 0;
    while (n < 3000 && !(txlog.len() > 0 && txlog[txlog.len()-1] == 8'h0A)) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic cmd_reply(string req, string cmd, string exp);
    txlog = "";
    send_line(cmd);
    wait_reply();
    check(txlog == exp, req, {"reply to ", cmd}, txlog, exp);
  endtask

  task automatic user_pass(string req, logic [7:0] b);
    @(negedge clk); #1;
    usr_valid = 1'b1; usr_data = b; #1;
    check(tx_valid && tx_data == b && usr_ready == tx_ready, req, "print pass-through",
          $sformatf("%b/%h", tx_valid, tx_data), $sformatf("1/%h", b));
    usr_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(!bus_req && !cpu_rst && !tx_valid && rx_ready, "R1", "reset outputs",
          $sformatf("%b%b%b%b", bus_req, cpu_rst, tx_valid, rx_ready), "0001");
    user_pass("R1", 8'h68);
  endtask

  task automatic t_enter_debug();
    send_byte(8'h0A);
    @(negedge clk); #1;
    usr_valid = 1'b1; usr_data = 8'h41; #1;
    check(usr_ready && !tx_valid, "R2", "print dropped in monitor",
          $sformatf("%b%b", usr_ready, tx_valid), "10");
    usr_valid = 1'b0;
  endtask

  task automatic t_read();
    int c0 = bus_cnt;
    cmd_reply("R3", "10000\n", $sformatf("%08h\n", 32'h10000 ^ RMASK));
    check(bus_cnt == c0 + 1 && !last_we && last_addr == 32'h10000, "R3", "one read",
          $sformatf("%0d/%b/%h", bus_cnt - c0, last_we, last_addr), "1/0/00010000");
    cmd_reply("R9", "00020008\n", $sformatf("%08h\n", 32'h20008 ^ RMASK));
  endtask

  task automatic t_read_case_crlf();
    int c0 = bus_cnt;
    cmd_reply("R9", "AbD\r\n", $sformatf("%08h\n", 32'habc ^ RMASK));
    repeat (40) @(negedge clk);
    check(txlog == $sformatf("%08h\n", 32'habc ^ RMASK) && bus_cnt == c0 + 1, "R8",
          "crlf gives one reply", txlog, "single reply");
    check(last_addr == 32'habc, "R11", "low bits cleared",
          $sformatf("%h", last_addr), "00000abc");
  endtask

  task automatic t_write();
    cmd_reply("R4", "20004 1276ACD0\r", "wr done\n");
    check(last_we && last_addr == 32'h20004 && last_wdata == 32'h1276acd0, "R4", "write",
          $sformatf("%b/%h/%h", last_we, last_addr, last_wdata), "1/00020004/1276acd0");
  endtask

  task automatic t_empty();
    int c0 = bus_cnt;
    txlog = "";
    send_line("\n\r");
    repeat (40) @(negedge clk);
    check(txlog == "" && bus_cnt == c0, "R8", "empty line silent", txlog, "");
  endtask

  task automatic t_invalid();
    int c0 = bus_cnt;
    cmd_reply("R7", "^^$x\n", "invalid\n");
    cmd_reply("R7", "r\n", "invalid\n");
    cmd_reply("R7", "123456789\n", "invalid\n");
    cmd_reply("R7", "10 \n", "invalid\n");
    cmd_reply("R7", "o1\n", "invalid\n");
    check(bus_cnt == c0, "R7", "no bus access", $sformatf("%0d", bus_cnt - c0), "0");
  endtask

  task automatic t_stall_read();
    stall = 1;
    cmd_reply("R10", "fffffffc\n", $sformatf("%08h\n", 32'hfffffffc ^ RMASK));
    stall = 0;
    check(viol == 0, "R10", "no rx/tx while bus busy", $sformatf("%0d", viol), "0");
  endtask

  task automatic t_user_return();
    cmd_reply("R5", "o\n", "user\n");
    user_pass("R5", 8'h7a);
    send_byte(8'h0A);
  endtask

  task automatic t_cpu_reset();
    int r0 = rst_cnt;
    cmd_reply("R6", "r8000\n", "rst done\n");
    check(rst_cnt == r0 + 1 && last_boot == 32'h8000, "R6", "restart pulse",
          $sformatf("%0d/%h", rst_cnt - r0, last_boot), "1/00008000");
    user_pass("R6", 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enter_debug();
    t_read();
    t_read_case_crlf();
    t_write();
    t_empty();
    t_invalid();
    t_stall_read();
    t_user_return();
    t_cpu_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    checks++; errors++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule